// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is the interrupt-timer slice of a real-time clock. It counts 1 ms tick pulses and raises an interrupt once a programmed delay has elapsed, either once per start or continuously at a fixed period. A processor reaches it through a small strobe-based register bus. The bus has a select, a read strobe, a write strobe, a 4-bit address, and separate write and read data.

Two registers are visible. The control register at address 0 starts and stops timing and chooses which bank appears at address 15. When read, it reports the interrupt flag and a data-changed flag. The data-changed flag is set by every 100 ms clock-setting pulse. The interrupt word at address 15 holds a delay code and a repeat-mode bit. Both flags are cleared by the control read that observes them. The clear takes effect when that read strobe ends.

In repeat mode, every later timeout keeps the phase of the start write that began timing. Writing a start command again always begins a complete new delay period. All bus pins are plain control pins. The bus has no back-pressure: every access completes in the cycle its strobe is seen.

Top module: `pit_timer`

## Requirements
- R1: After reset, a control read returns 0x04 (stop bit set, bank 0, both flags clear), `irq` is low, and the timer is idle.
- R2: A control write stores bit 0 as the stop bit and bit 1 as the bank select. A write with bit 0 = 0 starts timing with a full delay period, even when timing is already running.
- R3: Address 15 is written only while the bank select is 1. While it is 1, a read of address 15 returns the stored 8-bit word. Bits [1:0] select a period of 1, 10, 100 or 1000 ticks for codes 0 to 3. Bit 4 = 1 selects repeat mode.
- R4: The first timeout happens on the P-th tick after a start write, where P is the period. It sets the interrupt flag and drives `irq` high.
- R5: In single mode, timing halts after one timeout. No further timeout occurs until the next start write.
- R6: In repeat mode, a timeout recurs every P ticks with no processor action.
- R7: A control write with bit 0 = 1 stops timing. No timeout occurs while stopped.
- R8: A control read returns the interrupt flag on bit 0, the bank on bit 1, the stop bit on bit 2 and the data-changed flag on bit 3. Flags seen as 1 by that read are cleared when its strobe ends, so a long strobe delays the clear.
- R9: The data-changed flag is set by each clock-setting pulse.
- R10: If a flag is set in the same cycle that a read clear would drop it, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every 1 ms |
| set_pulse | input | 1 | One-cycle pulse every 100 ms |
| bus_sel | input | 1 | Register bus select |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while selected and reading |
| irq | output | 1 | Interrupt request, follows the interrupt flag |

## Verification
The end of a control read, which clears the interrupt flag, can fall in the same cycle as a timeout, which sets it. To provoke this, the bench programs a 1-tick repeating period and reads the set flag. It then releases the read strobe at the very edge where the next tick arrives. It judges the result by `irq` staying high afterwards. A second, ordinary read then shows that the flag does clear when no timeout coincides.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'd0;
  localparam logic [ADDR_W-1:0] WORD_ADDR = 4'd15;
  localparam int REP_BIT = 4;

  // Tick count for each delay code
  function automatic int unsigned period_of(input logic [1:0] code);
    case (code)
      2'd0:    period_of = 1;
      2'd1:    period_of = 10;
      2'd2:    period_of = 100;
      default: period_of = 1000;
    endcase
  endfunction
endpackage

// File: rtl/pit_flag.sv
module pit_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd_active,
  input  logic rd_end,
  output logic flag
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      seen <= 1'b0;
    end else begin
      if (rd_end) seen <= 1'b0;
      else if (rd_active && flag) seen <= 1'b1;
      if (set_ev) flag <= 1'b1;
      else if (rd_end && seen) flag <= 1'b0;
    end
  end

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_ev));
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag);
  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(rd_end));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              irq_flag,
  input  logic              dchg_flag,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              start_ev,
  output logic              stop_ev,
  output logic [DATA_W-1:0] int_word,
  output logic              rd_ctrl,
  output logic              rd_end
);
  logic stop_q, bank_q, rd_q;
  logic wr_ctrl, wr_word;

  assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == CTRL_ADDR);
  assign wr_word  = bus_sel && bus_wr && (bus_addr == WORD_ADDR) && bank_q;
  assign rd_ctrl  = bus_sel && bus_rd && (bus_addr == CTRL_ADDR);
  assign rd_end   = rd_q && !rd_ctrl;
  assign start_ev = wr_ctrl && !bus_wdata[0];
  assign stop_ev  = wr_ctrl && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q   <= 1'b1;
      bank_q   <= 1'b0;
      rd_q     <= 1'b0;
      int_word <= '0;
    end else begin
      rd_q <= rd_ctrl;
      if (wr_ctrl) begin
        stop_q <= bus_wdata[0];
        bank_q <= bus_wdata[1];
      end
      if (wr_word) int_word <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && bus_rd) begin
      if (bus_addr == CTRL_ADDR)
        bus_rdata = {{(DATA_W-4){1'b0}}, dchg_flag, stop_q, bank_q, irq_flag};
      else if (bus_addr == WORD_ADDR && bank_q)
        bus_rdata = int_word;
    end
  end

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == WORD_ADDR && bank_q) |=> $stable(int_word));
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [1:0] code,
  input  logic       repeat_en,
  output logic       timeout
);
  logic [CNT_W-1:0] cnt, period;
  logic             run;

  assign period  = CNT_W'(period_of(code));
  assign timeout = run && tick && (cnt == CNT_W'(1)) && !start_ev && !stop_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start_ev) begin
      cnt <= period;
      run <= 1'b1;
    end else if (stop_ev) begin
      run <= 1'b0;
    end else if (run && tick) begin
      if (cnt == CNT_W'(1)) begin
        cnt <= period;
        run <= repeat_en;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R2
  start_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> run && cnt == $past(period));
  // R5
  single_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout && !repeat_en |=> !run);
  // R7
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !run);
  // R6
  nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt != '0);
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              set_pulse,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              start_ev, stop_ev, rd_ctrl, rd_end, timeout;
  logic              irq_flag, dchg_flag;
  logic [DATA_W-1:0] int_word;

  pit_regs u_regs (
    .clk, .rst_n, .bus_sel, .bus_rd, .bus_wr, .bus_addr, .bus_wdata,
    .irq_flag, .dchg_flag, .bus_rdata, .start_ev, .stop_ev,
    .int_word, .rd_ctrl, .rd_end
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .tick(tick_ms), .start_ev, .stop_ev,
    .code(int_word[1:0]), .repeat_en(int_word[REP_BIT]), .timeout
  );

  pit_flag u_irq_flag (
    .clk, .rst_n, .set_ev(timeout), .rd_active(rd_ctrl), .rd_end,
    .flag(irq_flag)
  );

  pit_flag u_dchg_flag (
    .clk, .rst_n, .set_ev(set_pulse), .rd_active(rd_ctrl), .rd_end,
    .flag(dchg_flag)
  );

  assign irq = irq_flag;
endmodule

// File: tb/pit_timer_test.sv
module pit_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam logic [7:0] VWORD [NV] = '{8'h00, 8'h01, 8'h12, 8'h11};
  localparam int VPER [NV] = '{1, 10, 100, 10};

  logic clk = 0, rst_n = 0, tick_ms = 0, set_pulse = 0;
  logic bus_sel = 0, bus_rd = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, d;
  logic irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_timer uut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_rd = 0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick_ms = 1;
      repeat (n) @(negedge clk);
      tick_ms = 0;
    end
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_irq();
    rd(4'd0, d); idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1; idle(1);
    // R1 reset state
    rd(4'd0, d); chk("R1 ctrl", d, 8'h04);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // Vector table: R3 codes, R4 first timeout, R8 read clear
    for (int i = 0; i < NV; i++) begin
      wr(4'd0, 8'h03); wr(4'd15, VWORD[i]); wr(4'd0, 8'h02);
      ticks(VPER[i] - 1);
      chk("R4 before timeout", {7'b0, irq}, 8'h00);
      ticks(1);
      chk("R4 at timeout", {7'b0, irq}, 8'h01);
      rd(4'd0, d); idle(1);
      chk("R8 cleared", {7'b0, d[0], irq}, 8'h02);
    end

    // R6 repeat continues (last vector: code 1 repeat)
    ticks(9);  chk("R6 quiet", {7'b0, irq}, 8'h00);
    ticks(1);  chk("R6 recurs", {7'b0, irq}, 8'h01);
    clear_irq();

    // R5 single halts, restart by start write
    wr(4'd0, 8'h03); wr(4'd15, 8'h01); wr(4'd0, 8'h02);
    ticks(10); chk("R5 first", {7'b0, irq}, 8'h01);
    clear_irq();
    ticks(30); chk("R5 halted", {7'b0, irq}, 8'h00);
    wr(4'd0, 8'h02);
    ticks(10); chk("R5 restart", {7'b0, irq}, 8'h01);
    clear_irq();

    // R7 stop, then full period after start
    wr(4'd0, 8'h03); wr(4'd15, 8'h11); wr(4'd0, 8'h02);
    ticks(5); wr(4'd0, 8'h01);
    ticks(20); chk("R7 stopped", {7'b0, irq}, 8'h00);
    wr(4'd0, 8'h00);
    ticks(9); chk("R7 full period quiet", {7'b0, irq}, 8'h00);
    ticks(1); chk("R7 full period", {7'b0, irq}, 8'h01);
    clear_irq();

    // R2 start while running restarts full period
    ticks(7); wr(4'd0, 8'h02);
    ticks(9); chk("R2 restart quiet", {7'b0, irq}, 8'h00);
    ticks(1); chk("R2 restart timeout", {7'b0, irq}, 8'h01);
    clear_irq();

    // R3 word write ignored while bank 0
    wr(4'd0, 8'h03); wr(4'd15, 8'h11);
    wr(4'd0, 8'h01); wr(4'd15, 8'h03);
    wr(4'd0, 8'h03); rd(4'd15, d);
    chk("R3 ignored write", d, 8'h11);

    // R9 data-changed flag
    @(negedge clk); set_pulse = 1; @(negedge clk); set_pulse = 0;
    rd(4'd0, d); chk("R9 set", {7'b0, d[3]}, 8'h01);
    idle(1);
    rd(4'd0, d); chk("R9 cleared by read", {7'b0, d[3]}, 8'h00);

    // R8 long strobe delays the clear
    wr(4'd0, 8'h03); wr(4'd15, 8'h00); wr(4'd0, 8'h02);
    ticks(1);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = 0;
    repeat (5) @(negedge clk);
    #1 chk("R8 held", {7'b0, irq}, 8'h01);
    bus_sel = 0; bus_rd = 0;
    idle(1); chk("R8 after release", {7'b0, irq}, 8'h00);

    // R4 longest code
    wr(4'd0, 8'h03); wr(4'd15, 8'h03); wr(4'd0, 8'h02);
    ticks(999); chk("R4 code3 quiet", {7'b0, irq}, 8'h00);
    ticks(1);   chk("R4 code3", {7'b0, irq}, 8'h01);
    clear_irq();

    // R10 timeout coincides with end of read
    wr(4'd0, 8'h03); wr(4'd15, 8'h10); wr(4'd0, 8'h02);
    ticks(1); chk("R10 set", {7'b0, irq}, 8'h01);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = 0;
    @(negedge clk); bus_sel = 0; bus_rd = 0; tick_ms = 1;
    @(negedge clk); tick_ms = 0;
    #1 chk("R10 set wins", {7'b0, irq}, 8'h01);
    clear_irq(); chk("R10 plain clear", {7'b0, irq}, 8'h00);
    wr(4'd0, 8'h03);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule